// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Collector

The collector gathers 64 level-sensitive request lines and turns them into one CPU interrupt line, a 6-bit vector number and a 32-bit vector address. Every source has a configuration lane that holds a 2-bit priority level, an enable and a software-force bit. Four lanes share one 32-bit configuration word. On every cycle the block picks one winner from the enabled requesting sources. The winner's number and address are then held in registers that software can read.

Software reaches the block over a simple 32-bit register bus. The bus has a write strobe, a read strobe, a byte address and write data. Read data is combinational and is valid in the same cycle as the read strobe. Each stored register can be reached at four addresses. The low address bits [3:2] choose plain write, OR-set, AND-clear or XOR-toggle.

Entering service is signalled either by a write to the vector register or, in read-entry mode, by a read of it. Each priority level has an in-service bit. A higher level can interrupt a lower one unless nesting is switched off. A level-acknowledge write ends service on the chosen levels.

Top module: `irq_collector`

## Requirements
- R1: After reset every configuration word, the control word, the in-service bits and the vector base read as zero, and irqOut and vecNum are 0.
- R2: Source n lives in the word at byte address 0x100 + (n/4)*0x10, in lane bits [(n%4)*8+7 : (n%4)*8]. Lane bit [1:0] is the priority level, bit 2 is the enable and bit 3 is the software force. The other lane bits read as zero.
- R3: For the configuration words, control (0x020) and vector base (0x060), address offset +0x0 writes the data, +0x4 ORs it in, +0x8 clears the bits that are set in the data and +0xC toggles them.
- R4: A source requests when its enable is set and either its line is high, its latched pending bit is set or its force bit is set. The winner is the requesting source with the highest level, and among equal levels the lowest index. vecNum and status register 0x010 bits [5:0] show the winner, and both show 0 when no source requests.
- R5: vecAddr and a read of 0x000 return the vector base, with its low two bits forced to zero, plus 4 times vecNum.
- R6: irqOut stays low while control bit 16 is clear.
- R7: When control bit 18 is clear, a write to 0x000 puts the current winner's level in service. When bit 18 is set, a read of 0x000 does this instead and a write does not. With no winner, neither access has any effect. The in-service bits read at 0x030 bits [3:0], with bit l standing for level l.
- R8: Writing a 1 to bit l of 0x030 ends service on level l.
- R9: With control bit 19 clear, irqOut is high only when the winner's level is above every level in service. With bit 19 set, irqOut is high only when no level is in service.
- R10: Registers 0x040 and 0x050 return request lines 31..0 and 63..32 with no masking.
- R11: A high line sets its source's pending latch. The latch stays set after the line falls. It is cleared by writing a 1 to bit n%32 of 0x070 (sources 0..31) or 0x080 (sources 32..63), and also when the source enters service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | 9 | Byte address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, combinational |
| reqLines | input | 64 | Level-sensitive request lines |
| irqOut | output | 1 | CPU interrupt request |
| vecNum | output | 6 | Current winning source number |
| vecAddr | output | 32 | Computed vector address |

## Verification
Register readback is combinational. The bench therefore samples it in the same cycle as the read strobe, half a period after driving it. Any change on a request line, any configuration or clear write, and any in-service change reaches irqOut, vecNum and vecAddr at the rising edge after the one that captured it. The bench always waits one extra falling edge after the access that completes before it samples those outputs. In-service bits are captured at the same edge as the entry or acknowledge access, so the read of 0x030 that follows already sees them.

// File: rtl/irq_collector_pkg.sv
package irq_collector_pkg;

  localparam int unsigned REG_W      = 32;
  localparam int unsigned ADDR_W     = 9;
  localparam int unsigned IDX_W      = ADDR_W - 4;
  localparam int unsigned PRIO_W     = 2;
  localparam int unsigned LEVELS     = 1 << PRIO_W;
  localparam int unsigned LANES      = 4;
  localparam int unsigned LANE_W     = REG_W / LANES;
  localparam int unsigned CFG_BITS   = 4;

  // register word indices (byte address >> 4)
  localparam logic [IDX_W-1:0] IDX_VECTOR = 5'h00;
  localparam logic [IDX_W-1:0] IDX_STATUS = 5'h01;
  localparam logic [IDX_W-1:0] IDX_CTRL   = 5'h02;
  localparam logic [IDX_W-1:0] IDX_ACK    = 5'h03;
  localparam logic [IDX_W-1:0] IDX_RAWLO  = 5'h04;
  localparam logic [IDX_W-1:0] IDX_RAWHI  = 5'h05;
  localparam logic [IDX_W-1:0] IDX_VBASE  = 5'h06;
  localparam logic [IDX_W-1:0] IDX_CLRLO  = 5'h07;
  localparam logic [IDX_W-1:0] IDX_CLRHI  = 5'h08;

  localparam int unsigned BIT_IRQ_EN     = 16;
  localparam int unsigned BIT_READ_ENTRY = 18;
  localparam int unsigned BIT_NO_NEST    = 19;

  typedef enum logic [1:0] {
    OP_WRITE  = 2'd0,
    OP_SET    = 2'd1,
    OP_CLEAR  = 2'd2,
    OP_TOGGLE = 2'd3
  } aliasOpT;

  typedef struct packed {
    logic             cfgWr;
    logic [3:0]       cfgIdx;
    logic             vbaseWr;
    logic             clrWr;
    logic             clrHigh;
    logic             enterSvc;
    aliasOpT          op;
    logic [REG_W-1:0] data;
  } strobeT;

  function automatic logic [REG_W-1:0] applyAlias(input logic [REG_W-1:0] oldV,
                                                  input logic [REG_W-1:0] wd,
                                                  input aliasOpT op);
    case (op)
      OP_SET:    return oldV | wd;
      OP_CLEAR:  return oldV & ~wd;
      OP_TOGGLE: return oldV ^ wd;
      default:   return wd;
    endcase
  endfunction

endpackage

// File: rtl/irq_collector_arb.sv
module irq_collector_arb
  import irq_collector_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  localparam int unsigned SRC_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]        effReq,
  input  logic [NUM_SRC*PRIO_W-1:0] srcPrio,
  output logic                      winValid,
  output logic [SRC_W-1:0]          winNum,
  output logic [PRIO_W-1:0]         winLevel
);

  logic             lvlHit;
  logic [SRC_W-1:0] lvlNum;

  // scan levels low to high so a higher level overrides; within a level,
  // scan sources high to low so the lowest index is kept
  always_comb begin
    winValid = 1'b0;
    winNum   = '0;
    winLevel = '0;
    lvlHit   = 1'b0;
    lvlNum   = '0;
    for (int l = 0; l < LEVELS; l++) begin
      lvlHit = 1'b0;
      lvlNum = '0;
      for (int n = NUM_SRC - 1; n >= 0; n--) begin
        if (effReq[n] && (srcPrio[n*PRIO_W +: PRIO_W] == PRIO_W'(l))) begin
          lvlHit = 1'b1;
          lvlNum = SRC_W'(n);
        end
      end
      if (lvlHit) begin
        winValid = 1'b1;
        winNum   = lvlNum;
        winLevel = PRIO_W'(l);
      end
    end
  end

endmodule

// File: rtl/irq_collector_dp.sv
module irq_collector_dp
  import irq_collector_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  localparam int unsigned SRC_W     = $clog2(NUM_SRC),
  localparam int unsigned CFG_WORDS = NUM_SRC / LANES
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             strobe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [NUM_SRC-1:0] reqLines,
  output logic               winValid,
  output logic [PRIO_W-1:0]  winLevel,
  output logic               curValid,
  output logic [PRIO_W-1:0]  curLevel,
  output logic [SRC_W-1:0]   vecNum,
  output logic [REG_W-1:0]   vecAddr,
  output logic [REG_W-1:0]   dpRdData
);

  localparam int unsigned WORD_LANE_BITS = LANES * CFG_BITS;

  logic [NUM_SRC*CFG_BITS-1:0] laneFlat;
  logic [CFG_WORDS*REG_W-1:0]  cfgFlat;
  logic [NUM_SRC*PRIO_W-1:0]   srcPrio;
  logic [NUM_SRC-1:0]          srcEn;
  logic [NUM_SRC-1:0]          srcSoft;
  logic [NUM_SRC-1:0]          pendLatch;
  logic [NUM_SRC-1:0]          effReq;
  logic [NUM_SRC-1:0]          clrMask;
  logic [NUM_SRC-1:0]          enterMask;
  logic [REG_W-3:0]            vbaseHi;
  logic [REG_W-1:0]            vbaseNext;
  logic [SRC_W-1:0]            winNum;
  logic [SRC_W-1:0]            curNum;
  logic [IDX_W-1:0]            rdIdx;

  // configuration words: four lanes each, stored as their meaningful bits
  for (genvar w = 0; w < CFG_WORDS; w++) begin : g_word
    logic [WORD_LANE_BITS-1:0] laneBits;
    logic [REG_W-1:0]          packedW;
    logic [REG_W-1:0]          nextW;

    always_comb begin
      packedW = '0;
      for (int k = 0; k < LANES; k++)
        packedW[k*LANE_W +: CFG_BITS] = laneBits[k*CFG_BITS +: CFG_BITS];
    end

    assign nextW = applyAlias(packedW, strobe.data, strobe.op);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        laneBits <= '0;
      end else if (strobe.cfgWr && (strobe.cfgIdx == 4'(w))) begin
        for (int k = 0; k < LANES; k++)
          laneBits[k*CFG_BITS +: CFG_BITS] <= nextW[k*LANE_W +: CFG_BITS];
      end
    end

    assign laneFlat[w*WORD_LANE_BITS +: WORD_LANE_BITS] = laneBits;
    assign cfgFlat[w*REG_W +: REG_W]                    = packedW;
  end

  always_comb begin
    for (int n = 0; n < NUM_SRC; n++) begin
      srcPrio[n*PRIO_W +: PRIO_W] = laneFlat[n*CFG_BITS +: PRIO_W];
      srcEn[n]                    = laneFlat[n*CFG_BITS + 2];
      srcSoft[n]                  = laneFlat[n*CFG_BITS + 3];
    end
  end

  assign effReq = srcEn & (reqLines | pendLatch | srcSoft);

  // pending latch: set by a high line, dropped by clear writes or service entry
  assign clrMask   = strobe.clrWr ? (NUM_SRC'(strobe.data) << (strobe.clrHigh ? 32 : 0)) : '0;
  assign enterMask = strobe.enterSvc ? (NUM_SRC'(1) << curNum) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendLatch <= '0;
    else       pendLatch <= (pendLatch | reqLines) & ~clrMask & ~enterMask;
  end

  assign vbaseNext = applyAlias({vbaseHi, 2'b00}, strobe.data, strobe.op);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               vbaseHi <= '0;
    else if (strobe.vbaseWr) vbaseHi <= vbaseNext[REG_W-1:2];
  end

  irq_collector_arb #(.NUM_SRC(NUM_SRC)) arb_i (
    .effReq  (effReq),
    .srcPrio (srcPrio),
    .winValid(winValid),
    .winNum  (winNum),
    .winLevel(winLevel)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curValid <= 1'b0;
      curNum   <= '0;
      curLevel <= '0;
    end else begin
      curValid <= winValid;
      curNum   <= winNum;
      curLevel <= winLevel;
    end
  end

  assign vecNum  = curNum;
  assign vecAddr = {vbaseHi, 2'b00} + REG_W'({curNum, 2'b00});

  assign rdIdx = busAddr[ADDR_W-1:4];

  always_comb begin
    dpRdData = '0;
    if (rdIdx[IDX_W-1]) begin
      if (int'(rdIdx[3:0]) < CFG_WORDS) dpRdData = cfgFlat[rdIdx[3:0]*REG_W +: REG_W];
    end else begin
      case (rdIdx)
        IDX_VECTOR: dpRdData = vecAddr;
        IDX_STATUS: dpRdData = REG_W'(curNum);
        IDX_RAWLO:  dpRdData = reqLines[31:0];
        IDX_RAWHI:  dpRdData = REG_W'(reqLines >> 32);
        IDX_VBASE:  dpRdData = {vbaseHi, 2'b00};
        default:    dpRdData = '0;
      endcase
    end
  end

  AST_WIN_REQUESTS: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> effReq[winNum]); // R4
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !winValid |-> (effReq == '0)); // R4

endmodule

// File: rtl/irq_collector_ctrl.sv
module irq_collector_ctrl
  import irq_collector_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWrData,
  input  logic              curValid,
  input  logic [PRIO_W-1:0] curLevel,
  input  logic              winValid,
  input  logic [PRIO_W-1:0] winLevel,
  output strobeT            strobe,
  output logic              ctrlRdHit,
  output logic [REG_W-1:0]  ctrlRdData,
  output logic              irqOut
);

  logic [IDX_W-1:0]  wordIdx;
  aliasOpT           op;
  logic              vecHit;
  logic              enBit;
  logic              readEntryBit;
  logic              noNestBit;
  logic [REG_W-1:0]  ctrlWord;
  logic [REG_W-1:0]  ctrlNext;
  logic [LEVELS-1:0] inSvc;
  logic [LEVELS-1:0] ackBits;
  logic [LEVELS-1:0] entryMask;
  logic [LEVELS-1:0] geMask;
  logic              gateOk;

  assign wordIdx = busAddr[ADDR_W-1:4];
  assign op      = aliasOpT'(busAddr[3:2]);
  assign vecHit  = (wordIdx == IDX_VECTOR);

  always_comb begin
    strobe          = '0;
    strobe.op       = op;
    strobe.data     = busWrData;
    strobe.cfgWr    = busWrEn && wordIdx[IDX_W-1];
    strobe.cfgIdx   = wordIdx[3:0];
    strobe.vbaseWr  = busWrEn && (wordIdx == IDX_VBASE);
    strobe.clrWr    = busWrEn && ((wordIdx == IDX_CLRLO) || (wordIdx == IDX_CLRHI));
    strobe.clrHigh  = (wordIdx == IDX_CLRHI);
    strobe.enterSvc = curValid && vecHit && (readEntryBit ? busRdEn : busWrEn);
  end

  always_comb begin
    ctrlWord                 = '0;
    ctrlWord[BIT_IRQ_EN]     = enBit;
    ctrlWord[BIT_READ_ENTRY] = readEntryBit;
    ctrlWord[BIT_NO_NEST]    = noNestBit;
  end

  assign ctrlNext = applyAlias(ctrlWord, busWrData, op);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enBit        <= 1'b0;
      readEntryBit <= 1'b0;
      noNestBit    <= 1'b0;
    end else if (busWrEn && (wordIdx == IDX_CTRL)) begin
      enBit        <= ctrlNext[BIT_IRQ_EN];
      readEntryBit <= ctrlNext[BIT_READ_ENTRY];
      noNestBit    <= ctrlNext[BIT_NO_NEST];
    end
  end

  // per-level in-service tracking
  assign ackBits   = (busWrEn && (wordIdx == IDX_ACK)) ? busWrData[LEVELS-1:0] : '0;
  assign entryMask = strobe.enterSvc ? (LEVELS'(1) << curLevel) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inSvc <= '0;
    else       inSvc <= (inSvc & ~ackBits) | entryMask;
  end

  always_comb begin
    for (int l = 0; l < LEVELS; l++) geMask[l] = (PRIO_W'(l) >= winLevel);
  end

  assign gateOk = noNestBit ? (inSvc == '0) : ((inSvc & geMask) == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= enBit && winValid && gateOk;
  end

  assign ctrlRdHit  = (wordIdx == IDX_CTRL) || (wordIdx == IDX_ACK);
  assign ctrlRdData = (wordIdx == IDX_CTRL) ? ctrlWord : REG_W'(inSvc);

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> $past(enBit)); // R6
  AST_NO_NEST_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (noNestBit && (inSvc != '0)) |=> !irqOut); // R9
  AST_ENTRY_MARKS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.enterSvc |=> ((inSvc & $past(entryMask)) == $past(entryMask))); // R7
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    ((ackBits & ~entryMask) != '0) |=> ((inSvc & $past(ackBits & ~entryMask)) == '0)); // R8

endmodule

// File: rtl/irq_collector.sv
module irq_collector
  import irq_collector_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  localparam int unsigned SRC_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [REG_W-1:0]   busWrData,
  output logic [REG_W-1:0]   busRdData,
  input  logic [NUM_SRC-1:0] reqLines,
  output logic               irqOut,
  output logic [SRC_W-1:0]   vecNum,
  output logic [REG_W-1:0]   vecAddr
);

  strobeT            strobe;
  logic              winValid;
  logic [PRIO_W-1:0] winLevel;
  logic              curValid;
  logic [PRIO_W-1:0] curLevel;
  logic              ctrlRdHit;
  logic [REG_W-1:0]  ctrlRdData;
  logic [REG_W-1:0]  dpRdData;

  irq_collector_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .busWrEn   (busWrEn),
    .busRdEn   (busRdEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .curValid  (curValid),
    .curLevel  (curLevel),
    .winValid  (winValid),
    .winLevel  (winLevel),
    .strobe    (strobe),
    .ctrlRdHit (ctrlRdHit),
    .ctrlRdData(ctrlRdData),
    .irqOut    (irqOut)
  );

  irq_collector_dp #(.NUM_SRC(NUM_SRC)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busAddr  (busAddr),
    .reqLines (reqLines),
    .winValid (winValid),
    .winLevel (winLevel),
    .curValid (curValid),
    .curLevel (curLevel),
    .vecNum   (vecNum),
    .vecAddr  (vecAddr),
    .dpRdData (dpRdData)
  );

  assign busRdData = ctrlRdHit ? ctrlRdData : dpRdData;

endmodule

// File: tb/irq_collector_tb_top.sv
module irq_collector_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  localparam logic [8:0] A_VEC   = 9'h000;
  localparam logic [8:0] A_STAT  = 9'h010;
  localparam logic [8:0] A_CTRL  = 9'h020;
  localparam logic [8:0] A_ACK   = 9'h030;
  localparam logic [8:0] A_RAWLO = 9'h040;
  localparam logic [8:0] A_RAWHI = 9'h050;
  localparam logic [8:0] A_VBASE = 9'h060;
  localparam logic [8:0] A_CLRLO = 9'h070;
  localparam logic [8:0] A_CLRHI = 9'h080;

  logic        clk = 1'b0;
  logic        rstN;
  logic        busWrEn;
  logic        busRdEn;
  logic [8:0]  busAddr;
  logic [31:0] busWrData;
  logic [31:0] busRdData;
  logic [63:0] reqLines;
  logic        irqOut;
  logic [5:0]  vecNum;
  logic [31:0] vecAddr;

  int          checks   = 0;
  int          failures = 0;
  bit          done     = 1'b0;
  logic [31:0] cfgM [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_collector dut_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .reqLines(reqLines), .irqOut(irqOut), .vecNum(vecNum), .vecAddr(vecAddr)
  );

  function automatic logic [8:0] cfgAddr(input int w);
    return 9'(32'h100 + w * 16);
  endfunction

  // expected winner: {valid, level[1:0], num[5:0]}
  function automatic logic [8:0] expWin(input logic [63:0] rq);
    logic       valid = 1'b0;
    logic [1:0] lvl   = '0;
    logic [5:0] num   = '0;
    for (int n = 0; n < 64; n++) begin
      logic [3:0] lane = cfgM[n/4][(n%4)*8 +: 4];
      if (lane[2] && (rq[n] || lane[3]) && (!valid || lane[1:0] > lvl)) begin
        valid = 1'b1; lvl = lane[1:0]; num = 6'(n);
      end
    end
    return {valid, lvl, num};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic busWrite(input logic [8:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [8:0] a, output logic [31:0] d);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [8:0]  ew;
    logic [31:0] vb;
    logic [63:0] rq;
    void'($urandom(32'd20240611));
    rstN = 1'b0; busWrEn = 1'b0; busRdEn = 1'b0; busAddr = '0; busWrData = '0; reqLines = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick();

    // R1 reset state
    busRead(cfgAddr(0), rd);  check("R1 cfg0", rd, 0);
    busRead(cfgAddr(15), rd); check("R1 cfg15", rd, 0);
    busRead(A_CTRL, rd);      check("R1 ctrl", rd, 0);
    busRead(A_ACK, rd);       check("R1 insvc", rd, 0);
    busRead(A_VBASE, rd);     check("R1 vbase", rd, 0);
    check("R1 irq", irqOut, 0);
    check("R1 vecnum", vecNum, 0);

    // R2 lane layout
    busWrite(cfgAddr(2), 32'hFFFF_FFFF);
    busRead(cfgAddr(2), rd);  check("R2 lane bits", rd, 32'h0F0F_0F0F);
    busWrite(cfgAddr(2), 32'h0);

    // R3 aliases on vector base and a config word
    busWrite(A_VBASE, 32'h1000_0003);       busRead(A_VBASE, rd); check("R3 plain", rd, 32'h1000_0000);
    busWrite(A_VBASE + 9'h4, 32'h0000_0100); busRead(A_VBASE, rd); check("R3 set", rd, 32'h1000_0100);
    busWrite(A_VBASE + 9'h8, 32'h1000_0000); busRead(A_VBASE, rd); check("R3 clear", rd, 32'h0000_0100);
    busWrite(A_VBASE + 9'hC, 32'h0000_0104); busRead(A_VBASE, rd); check("R3 toggle", rd, 32'h0000_0004);
    busWrite(cfgAddr(0) + 9'h4, 32'h0500_0000);
    busWrite(cfgAddr(0) + 9'hC, 32'h0100_0000);
    busRead(cfgAddr(0), rd); check("R3 cfg toggle", rd, 32'h0400_0000);

    // directed service flow
    busWrite(A_VBASE, 32'h2000_0000);
    busWrite(cfgAddr(0), 32'h0500_0000);  // src3 level1
    busWrite(cfgAddr(5), 32'h0000_0006);  // src20 level2
    busWrite(cfgAddr(15), 32'h0000_0007); // src60 level3
    reqLines[3] = 1'b1; tick();
    check("R4 win src3", vecNum, 6'd3);
    check("R5 vecaddr src3", vecAddr, 32'h2000_000C);
    check("R6 irq gated off", irqOut, 0);
    busWrite(A_CTRL, 32'h0001_0000); tick();
    check("R6 irq on", irqOut, 1);
    busRead(A_STAT, rd); check("R4 status", rd, 3);
    busRead(A_VEC, rd);  check("R5 vec read", rd, 32'h2000_000C);
    busRead(A_ACK, rd);  check("R7 read no entry in write mode", rd, 0);
    busWrite(A_VEC, 32'h0);
    busRead(A_ACK, rd);  check("R7 write entry", rd, 32'h2);
    check("R9 same level blocked", irqOut, 0);
    reqLines[20] = 1'b1; tick();
    check("R4 win src20", vecNum, 6'd20);
    check("R9 higher nests", irqOut, 1);
    busWrite(A_CTRL + 9'h4, 32'h0008_0000); tick();
    check("R9 no-nest blocks", irqOut, 0);
    busRead(A_CTRL, rd); check("R3 ctrl set", rd, 32'h0009_0000);
    busWrite(A_CTRL + 9'h8, 32'h0008_0000); tick();
    check("R9 nesting back", irqOut, 1);
    busWrite(A_VEC, 32'h0);
    busRead(A_ACK, rd);  check("R7 nested entry", rd, 32'h6);
    busWrite(A_ACK, 32'h4);
    busRead(A_ACK, rd);  check("R8 ack level2", rd, 32'h2);
    reqLines[20] = 1'b0; tick();
    check("R11 latched after line low", vecNum, 6'd20);
    busWrite(A_CLRLO, 32'h0010_0000); tick();
    check("R11 clear drops latch", vecNum, 6'd3);
    check("R9 level1 still blocked", irqOut, 0);
    busWrite(A_CTRL + 9'h4, 32'h0004_0000);
    busWrite(A_VEC, 32'h0);
    busRead(A_ACK, rd);  check("R7 write ignored in read mode", rd, 32'h2);
    reqLines[60] = 1'b1; tick();
    check("R4 win src60", vecNum, 6'd60);
    check("R9 level3 nests", irqOut, 1);
    busRead(A_VEC, rd);  check("R5 vec src60", rd, 32'h2000_00F0);
    busRead(A_ACK, rd);  check("R7 read entry", rd, 32'hA);
    busWrite(A_ACK, 32'hF);
    busRead(A_ACK, rd);  check("R8 ack all", rd, 0);

    // software force
    reqLines = '0; tick();
    busWrite(A_CLRLO, 32'hFFFF_FFFF);
    busWrite(A_CLRHI, 32'hFFFF_FFFF);
    busWrite(cfgAddr(8) + 9'h4, 32'h0000_0C00); tick();
    check("R4 soft force src33", vecNum, 6'd33);
    check("R9 irq idle svc", irqOut, 1);

    // raw view
    reqLines = 64'hA5A5_0F0F_1234_8001; tick();
    busRead(A_RAWLO, rd); check("R10 raw low", rd, 32'h1234_8001);
    busRead(A_RAWHI, rd); check("R10 raw high", rd, 32'hA5A5_0F0F);

    // entry with no winner
    reqLines = '0; tick();
    busWrite(A_CLRLO, 32'hFFFF_FFFF);
    busWrite(A_CLRHI, 32'hFFFF_FFFF);
    busWrite(cfgAddr(8), 32'h0);
    busWrite(A_CTRL, 32'h0001_0000); tick();
    busWrite(A_VEC, 32'h0);
    busRead(A_ACK, rd);   check("R7 no winner no entry", rd, 0);
    check("R4 idle vecnum", vecNum, 0);
    check("R6 idle irq", irqOut, 0);

    // random arbitration
    for (int it = 0; it < 40; it++) begin
      reqLines = '0; tick();
      busWrite(A_CLRLO, 32'hFFFF_FFFF);
      busWrite(A_CLRHI, 32'hFFFF_FFFF);
      busWrite(A_ACK, 32'hF);
      busWrite(A_CTRL, 32'h0001_0000);
      vb = $urandom & 32'hFFFF_FFFC;
      busWrite(A_VBASE, vb);
      for (int w = 0; w < 16; w++) begin
        cfgM[w] = $urandom & ((it % 4 == 0) ? 32'h0F0F_0F0F : 32'h0707_0707);
        busWrite(cfgAddr(w), cfgM[w]);
      end
      rq = {$urandom, $urandom} & {$urandom, $urandom};
      if (it % 5 == 0) rq = '0;
      reqLines = rq; tick();
      ew = expWin(rq);
      check("R4 random winner", vecNum, ew[5:0]);
      check("R5 random vecaddr", vecAddr, vb + {24'h0, ew[5:0], 2'b00});
      check("R9 random irq", irqOut, ew[8]);
      busRead(A_STAT, rd); check("R4 random status", rd, {26'h0, ew[5:0]});
      busRead(cfgAddr(it % 16), rd); check("R2 random readback", rd, cfgM[it % 16]);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule